// File: doc/BRIEF.md
# Dual-Endian Virtual-ISA Slot Decoder

This block turns 64-bit instruction slots of a packet-filter style virtual machine into the control fields a pipeline needs. A static strap selects whether slots are encoded little-endian or big-endian. For each accepted slot the decoder reports the class, the operation and source-selector split of the code byte, and the mode and size split of the same byte. It also reports the destination and source register indices, a sign-extended offset and a sign-extended immediate. The outputs are registered and appear in the cycle after the slot is accepted, as a one-cycle pulse.

One instruction, the wide-constant load, spans two slots. The decoder keeps the first slot, emits nothing, and waits for the next accepted slot. Only the immediate field of that second slot is used. It then issues a single decode that carries the assembled 64-bit constant. Reserved load/store modes and operation codes above 13 raise an illegal pulse in place of a valid decode. One encoding is reported as a breakpoint: class ALU (32-bit), register source, operation 8.

Top module: `slot_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, decValid and decIllegal are low, and the decoder is not waiting for a second slot.
- R2: A legal slot accepted at a clock edge produces decValid high for exactly the following cycle, with decIllegal and decWide low. decOp is code bits 7:4, decSrcSel is code bit 3 (1 selects the source register) and decClass is code bits 2:0 (LD=0, LDX=1, ST=2, STX=3, ALU=4, JMP=5, JMP32=6, ALU64=7). The code byte is slot byte 0 (slotData[7:0]).
- R3: decMode reports code bits 7:5 and decSize reports code bits 4:3 (00 word, 01 half, 10 byte, 11 double).
- R4: With bigEndian low, decDst is the low nibble and decSrc the high nibble of slot byte 1.
- R5: With bigEndian high, decDst is the high nibble and decSrc the low nibble of slot byte 1.
- R6: The offset comes from slot bytes 2..3 and the immediate from bytes 4..7. With little-endian encoding the lowest-numbered byte is least significant; with big-endian it is most significant. Both are sign-extended to 64 bits on decOffset and decImm.
- R7: A slot with code 0x18 (class LD, size double, mode 000) produces no output. The next accepted slot completes it: one cycle later decValid and decWide are high, and decImm holds the second slot's immediate in bits 63:32 and the first slot's immediate in bits 31:0. Cycles without slotValid in between do not end the wait.
- R8: For a completed wide load, decClass, decOp, decSrcSel, decMode, decSize, decDst, decSrc and decOffset come from the first slot. The second slot's code, register and offset bytes are ignored, even when they encode an illegal instruction.
- R9: A load/store-class slot (class 0..3) whose mode is 100, 101 or 111 gives decIllegal high for one cycle with decValid low.
- R10: An ALU, ALU64, JMP or JMP32 slot whose operation code is 14 or 15 gives decIllegal high for one cycle with decValid low.
- R11: Code 0x8C (class ALU, source-register selector, operation 8) decodes as valid with decBreak high. decBreak is low for every other decode, including code 0x8F, the same fields in class ALU64.
- R12: slotReady is high out of reset. A cycle without slotValid yields no decValid or decIllegal in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | Static encoding select, 1 = big-endian |
| slotValid | input | 1 | Slot offered |
| slotReady | output | 1 | Slot can be taken |
| slotData | input | 64 | Instruction slot, byte 0 in bits 7:0 |
| decValid | output | 1 | Valid decode pulse |
| decIllegal | output | 1 | Illegal encoding pulse |
| decWide | output | 1 | Decode is a completed two-slot constant load |
| decBreak | output | 1 | Decode is the breakpoint encoding |
| decClass | output | 3 | Instruction class |
| decOp | output | 4 | ALU/jump operation |
| decSrcSel | output | 1 | 1 = source register, 0 = immediate |
| decMode | output | 3 | Load/store mode |
| decSize | output | 2 | Load/store access size |
| decDst | output | 4 | Destination register index |
| decSrc | output | 4 | Source register index |
| decOffset | output | 64 | Sign-extended offset |
| decImm | output | 64 | Sign-extended immediate or wide constant |

## Verification
The hardest situation to reach is a wide load whose second slot would decode as illegal on its own, arriving after idle cycles in the waiting state. The sweep covers every code byte under both encodings. Each time code 0x18 comes up, the bench inserts an idle cycle and then offers a second slot with code 0xFF and scrambled bytes. The result must carry only that slot's immediate, and every other field must come from the first slot.

// File: rtl/slot_dec_pkg.sv
package slot_dec_pkg;

  typedef enum logic [2:0] {
    CLS_LD    = 3'd0,
    CLS_LDX   = 3'd1,
    CLS_ST    = 3'd2,
    CLS_STX   = 3'd3,
    CLS_ALU   = 3'd4,
    CLS_JMP   = 3'd5,
    CLS_JMP32 = 3'd6,
    CLS_ALU64 = 3'd7
  } insnClass_e;

  localparam logic [3:0] OP_BREAK = 4'h8;  // negate slot reused as breakpoint
  localparam logic [3:0] OP_LAST  = 4'hd;  // highest defined operation
  localparam logic [1:0] SZ_DOUBLE = 2'b11;
  localparam logic [2:0] MODE_IMM  = 3'b000;

  typedef struct packed {
    logic captureHead;  // keep first half of a wide load
    logic emitNormal;   // issue decode of current slot
    logic emitIllegal;  // flag current slot illegal
    logic emitWide;     // issue wide decode from held head
  } decStrobe_t;

endpackage

// File: rtl/slot_dec_ctrl.sv
module slot_dec_ctrl
  import slot_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotValid,
  input  logic       slotIllegal,
  input  logic       slotWideHead,
  output decStrobe_t strobe,
  output logic       waitingHi
);

  typedef enum logic {ST_IDLE, ST_WAIT_HI} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (slotValid) begin
      if (state == ST_WAIT_HI) begin
        strobe.emitWide = 1'b1;
        stateNext       = ST_IDLE;
      end else if (slotIllegal) begin
        strobe.emitIllegal = 1'b1;
      end else if (slotWideHead) begin
        strobe.captureHead = 1'b1;
        stateNext          = ST_WAIT_HI;
      end else begin
        strobe.emitNormal = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign waitingHi = (state == ST_WAIT_HI);

  AST_HEAD_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (!waitingHi && slotValid && slotWideHead && !slotIllegal) |=> waitingHi); // R7

  AST_WAIT_ENDS_ON_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (waitingHi && slotValid) |=> !waitingHi); // R7

  AST_WAIT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (waitingHi && !slotValid) |=> waitingHi); // R7

endmodule

// File: rtl/slot_dec_path.sv
module slot_dec_path
  import slot_dec_pkg::*;
#(
  parameter int IMM_W = 32,
  parameter int OFF_W = 16,
  parameter int RIDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bigEndian,
  input  logic [SLOT_W-1:0]    slotData,
  input  decStrobe_t           strobe,
  output logic                 slotIllegal,
  output logic                 slotWideHead,
  output logic                 decValid,
  output logic                 decIllegal,
  output logic                 decWide,
  output logic                 decBreak,
  output logic [2:0]           decClass,
  output logic [3:0]           decOp,
  output logic                 decSrcSel,
  output logic [2:0]           decMode,
  output logic [1:0]           decSize,
  output logic [RIDX_W-1:0]    decDst,
  output logic [RIDX_W-1:0]    decSrc,
  output logic [XLEN-1:0]      decOffset,
  output logic [XLEN-1:0]      decImm
);

  localparam int XLEN      = 2 * IMM_W;
  localparam int SLOT_W    = 16 + OFF_W + IMM_W;
  localparam int OFF_BYTES = OFF_W / 8;
  localparam int IMM_BYTES = IMM_W / 8;
  localparam int OFF_BASE  = 2;
  localparam int IMM_BASE  = OFF_BASE + OFF_BYTES;

  logic [7:0]        codeByte, regByte;
  logic [OFF_W-1:0]  offLe, offBe, offCur;
  logic [IMM_W-1:0]  immLe, immBe, immCur;
  logic [RIDX_W-1:0] dstCur, srcCur;

  assign codeByte = slotData[7:0];
  assign regByte  = slotData[15:8];

  for (genvar k = 0; k < OFF_BYTES; k++) begin : g_offLane
    assign offLe[8*k +: 8] = slotData[8*(OFF_BASE + k) +: 8];
    assign offBe[8*k +: 8] = slotData[8*(OFF_BASE + OFF_BYTES - 1 - k) +: 8];
  end
  for (genvar k = 0; k < IMM_BYTES; k++) begin : g_immLane
    assign immLe[8*k +: 8] = slotData[8*(IMM_BASE + k) +: 8];
    assign immBe[8*k +: 8] = slotData[8*(IMM_BASE + IMM_BYTES - 1 - k) +: 8];
  end

  assign offCur = bigEndian ? offBe : offLe;
  assign immCur = bigEndian ? immBe : immLe;
  assign dstCur = bigEndian ? regByte[7:4] : regByte[3:0];
  assign srcCur = bigEndian ? regByte[3:0] : regByte[7:4];

  logic isLdSt, modeReserved, opUnknown, isBreak;
  assign isLdSt       = !codeByte[2];
  assign modeReserved = (codeByte[7:5] == 3'b100) || (codeByte[7:5] == 3'b101) ||
                        (codeByte[7:5] == 3'b111);
  assign opUnknown    = codeByte[7:4] > OP_LAST;
  assign slotIllegal  = isLdSt ? modeReserved : opUnknown;
  assign slotWideHead = (codeByte[2:0] == CLS_LD) && (codeByte[4:3] == SZ_DOUBLE) &&
                        (codeByte[7:5] == MODE_IMM);
  assign isBreak      = (codeByte[2:0] == CLS_ALU) && codeByte[3] && (codeByte[7:4] == OP_BREAK);

  // first half of a wide load
  logic [7:0]        headCode;
  logic [RIDX_W-1:0] headDst, headSrc;
  logic [OFF_W-1:0]  headOff;
  logic [IMM_W-1:0]  headLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headCode <= '0;
      headDst  <= '0;
      headSrc  <= '0;
      headOff  <= '0;
      headLo   <= '0;
    end else if (strobe.captureHead) begin
      headCode <= codeByte;
      headDst  <= dstCur;
      headSrc  <= srcCur;
      headOff  <= offCur;
      headLo   <= immCur;
    end
  end

  logic [7:0]        selCode;
  logic [RIDX_W-1:0] selDst, selSrc;
  logic [OFF_W-1:0]  selOff;
  logic [XLEN-1:0]   selImm;

  always_comb begin
    if (strobe.emitWide) begin
      selCode = headCode;
      selDst  = headDst;
      selSrc  = headSrc;
      selOff  = headOff;
      selImm  = {immCur, headLo};
    end else begin
      selCode = codeByte;
      selDst  = dstCur;
      selSrc  = srcCur;
      selOff  = offCur;
      selImm  = {{(XLEN-IMM_W){immCur[IMM_W-1]}}, immCur};
    end
  end

  logic emitAny;
  assign emitAny = strobe.emitNormal | strobe.emitWide | strobe.emitIllegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid   <= 1'b0;
      decIllegal <= 1'b0;
      decWide    <= 1'b0;
      decBreak   <= 1'b0;
      decClass   <= '0;
      decOp      <= '0;
      decSrcSel  <= 1'b0;
      decMode    <= '0;
      decSize    <= '0;
      decDst     <= '0;
      decSrc     <= '0;
      decOffset  <= '0;
      decImm     <= '0;
    end else begin
      decValid   <= strobe.emitNormal | strobe.emitWide;
      decIllegal <= strobe.emitIllegal;
      decWide    <= strobe.emitWide;
      decBreak   <= strobe.emitNormal & isBreak;
      if (emitAny) begin
        decClass  <= selCode[2:0];
        decOp     <= selCode[7:4];
        decSrcSel <= selCode[3];
        decMode   <= selCode[7:5];
        decSize   <= selCode[4:3];
        decDst    <= selDst;
        decSrc    <= selSrc;
        decOffset <= {{(XLEN-OFF_W){selOff[OFF_W-1]}}, selOff};
        decImm    <= selImm;
      end
    end
  end

  AST_WIDE_IS_DOUBLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    decWide |-> (decValid && decClass == CLS_LD && decSize == SZ_DOUBLE && decMode == MODE_IMM)); // R7

  AST_BREAK_IS_ALU_REG: assert property (@(posedge clk) disable iff (!rstN)
    decBreak |-> (decValid && decClass == CLS_ALU && decSrcSel && decOp == OP_BREAK)); // R11

endmodule

// File: rtl/slot_decoder.sv
module slot_decoder
  import slot_dec_pkg::*;
#(
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16,
  parameter int RIDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bigEndian,
  input  logic                  slotValid,
  output logic                  slotReady,
  input  logic [63:0]           slotData,
  output logic                  decValid,
  output logic                  decIllegal,
  output logic                  decWide,
  output logic                  decBreak,
  output logic [2:0]            decClass,
  output logic [3:0]            decOp,
  output logic                  decSrcSel,
  output logic [2:0]            decMode,
  output logic [1:0]            decSize,
  output logic [RIDX_W-1:0]     decDst,
  output logic [RIDX_W-1:0]     decSrc,
  output logic [63:0]           decOffset,
  output logic [63:0]           decImm
);

  decStrobe_t strobe;
  logic slotIllegal, slotWideHead, waitingHi;

  assign slotReady = 1'b1;

  slot_dec_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .slotValid    (slotValid),
    .slotIllegal  (slotIllegal),
    .slotWideHead (slotWideHead),
    .strobe       (strobe),
    .waitingHi    (waitingHi)
  );

  slot_dec_path #(.IMM_W(IMM_W), .OFF_W(OFF_W), .RIDX_W(RIDX_W)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .bigEndian    (bigEndian),
    .slotData     (slotData),
    .strobe       (strobe),
    .slotIllegal  (slotIllegal),
    .slotWideHead (slotWideHead),
    .decValid     (decValid),
    .decIllegal   (decIllegal),
    .decWide      (decWide),
    .decBreak     (decBreak),
    .decClass     (decClass),
    .decOp        (decOp),
    .decSrcSel    (decSrcSel),
    .decMode      (decMode),
    .decSize      (decSize),
    .decDst       (decDst),
    .decSrc       (decSrc),
    .decOffset    (decOffset),
    .decImm       (decImm)
  );

  AST_VALID_EXCLUDES_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !(decValid && decIllegal)); // R9

  AST_QUIET_IN_QUIET_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> (!decValid && !decIllegal)); // R12

  AST_SECOND_SLOT_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    (waitingHi && slotValid) |=> (decValid && decWide)); // R7

  AST_HEAD_IS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!waitingHi && slotValid && slotWideHead) |=> (!decValid && !decIllegal)); // R7

endmodule

// File: tb/sim_slot_decoder.sv
`timescale 1ns/1ps
module sim_slot_decoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, bigEndian, slotValid, slotReady;
  logic [63:0] slotData;
  logic        decValid, decIllegal, decWide, decBreak, decSrcSel;
  logic [2:0]  decClass, decMode;
  logic [3:0]  decOp, decDst, decSrc;
  logic [1:0]  decSize;
  logic [63:0] decOffset, decImm;

  slot_decoder u0 (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .slotValid(slotValid),
    .slotReady(slotReady), .slotData(slotData), .decValid(decValid),
    .decIllegal(decIllegal), .decWide(decWide), .decBreak(decBreak),
    .decClass(decClass), .decOp(decOp), .decSrcSel(decSrcSel), .decMode(decMode),
    .decSize(decSize), .decDst(decDst), .decSrc(decSrc), .decOffset(decOffset),
    .decImm(decImm)
  );

  int nChk = 0;
  int nBad = 0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkSlot(logic [7:0] code, int salt);
    logic [7:0] s;
    s = 8'(salt);
    return {code ^ 8'h3c ^ s, ~s, 8'(s * 8'd5), 8'(s + 8'd7),
            s ^ 8'h80, 8'(s * 8'd3), code ^ 8'h5a ^ (s << 1), code};
  endfunction

  function automatic logic [7:0] byteOf(logic [63:0] d, int i);
    return d[8*i +: 8];
  endfunction

  function automatic logic [63:0] expOff(logic [63:0] d, logic be);
    logic [15:0] r;
    r = be ? {byteOf(d, 2), byteOf(d, 3)} : {byteOf(d, 3), byteOf(d, 2)};
    return {{48{r[15]}}, r};
  endfunction

  function automatic logic [31:0] expImm32(logic [63:0] d, logic be);
    return be ? {byteOf(d, 4), byteOf(d, 5), byteOf(d, 6), byteOf(d, 7)}
              : {byteOf(d, 7), byteOf(d, 6), byteOf(d, 5), byteOf(d, 4)};
  endfunction

  function automatic logic [7:0] expRegs(logic [63:0] d, logic be);
    // {dst, src}
    return be ? {byteOf(d, 1)[7:4], byteOf(d, 1)[3:0]}
              : {byteOf(d, 1)[3:0], byteOf(d, 1)[7:4]};
  endfunction

  task automatic drive(logic [63:0] d);
    @(negedge clk);
    slotData  = d;
    slotValid = 1'b1;
    @(negedge clk);
    slotValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; bigEndian = 1'b0; slotValid = 1'b0; slotData = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 128'({decValid, decIllegal}), 128'(2'b00));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 128'({decValid, decIllegal}), 128'(2'b00));
    chk("R12 ready", 128'(slotReady), 128'(1'b1));
    // R1: not waiting -> a plain slot decodes at once
    drive(mkSlot(8'h07, 1));
    chk("R1 no pending wide", 128'({decValid, decWide}), 128'(2'b10));

    for (int e = 0; e < 2; e++) begin
      bigEndian = e[0];
      for (int c = 0; c < 256; c++) begin
        logic [7:0]  code;
        logic [63:0] d;
        logic        ldst, bad, wide, brk;
        code = 8'(c);
        d    = mkSlot(code, c + 17 * e);
        ldst = !code[2];
        bad  = ldst ? (code[7:5] == 3'd4 || code[7:5] == 3'd5 || code[7:5] == 3'd7)
                    : (code[7:4] > 4'd13);
        wide = (code == 8'h18);
        brk  = (code == 8'h8c);
        drive(d);
        if (bad) begin
          if (ldst) chk("R9 reserved mode", 128'({decValid, decIllegal}), 128'(2'b01));
          else      chk("R10 unknown op",   128'({decValid, decIllegal}), 128'(2'b01));
        end else if (wide) begin
          logic [63:0] hi;
          chk("R7 head silent", 128'({decValid, decIllegal}), 128'(2'b00));
          @(negedge clk);
          chk("R7 wait idle", 128'({decValid, decIllegal}), 128'(2'b00));
          hi = mkSlot(8'hff, c + 99 + e);
          drive(hi);
          chk("R7 wide valid", 128'({decValid, decIllegal, decWide, decBreak}), 128'(4'b1010));
          chk("R7 wide const", 128'(decImm), 128'({expImm32(hi, e[0]), expImm32(d, e[0])}));
          chk("R8 head fields",
              128'({decClass, decOp, decSrcSel, decMode, decSize, decDst, decSrc, decOffset}),
              128'({code[2:0], code[7:4], code[3], code[7:5], code[4:3], expRegs(d, e[0]), expOff(d, e[0])}));
        end else begin
          chk("R2 valid", 128'({decValid, decIllegal, decWide}), 128'(3'b100));
          chk("R2 alu split", 128'({decOp, decSrcSel, decClass}), 128'({code[7:4], code[3], code[2:0]}));
          chk("R3 ldst split", 128'({decMode, decSize}), 128'({code[7:5], code[4:3]}));
          if (e == 0) chk("R4 le regs", 128'({decDst, decSrc}), 128'(expRegs(d, 1'b0)));
          else        chk("R5 be regs", 128'({decDst, decSrc}), 128'(expRegs(d, 1'b1)));
          chk("R6 offset", 128'(decOffset), 128'(expOff(d, e[0])));
          chk("R6 imm", 128'(decImm),
              128'({{32{expImm32(d, e[0])[31]}}, expImm32(d, e[0])}));
          chk("R11 break", 128'(decBreak), 128'(brk));
        end
        if ((c % 16) == 5) begin
          @(negedge clk);
          chk("R12 quiet", 128'({decValid, decIllegal}), 128'(2'b00));
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule